// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable, cycle-level model of a synchronous static RAM that needs no idle cycle when the data bus changes direction. On each enabled rising clock edge it registers a command, an address and active-low byte write masks. It then runs read and write data phases that are equally long, so reads and writes can be issued back to back in any mix. A mode input picks the data latency. With flow-through timing, the data phase is the cycle right after the command edge. With pipelined timing, the data phase is one enabled edge later.

Writes use a late-write scheme: the write data is sampled at the enabled edge that closes the write's data phase. A read issued right after a write to the same word returns the new data. The data bus is split into an input, an output and an output enable, so the pads can sit outside the block. An attached burst counter creates the next address when the advance control is high. It can count in linear or interleaved order, and it wraps after four accesses. The storage is a small register array sized by parameters.

Top module: `zt_sram`

## Requirements
- R1: A new command is taken only on an edge with `cke_n` low and `adv_ld` low. The device counts as selected only when `ce1_n` is low, `ce2` is high and `ce3_n` is low. A load edge with any of these inactive is a deselect, and its data phase leaves `dq_oe` low.
- R2: A read loaded with `we_n` high drives the word at its address. In flow-through mode (`pipe_mode`=0) the data appears in the cycle after the edge that registered the command. In pipelined mode (`pipe_mode`=1) it appears after the next enabled edge.
- R3: Write data on `dq_i` is sampled at the first enabled edge after the command edge in flow-through mode, and at the second enabled edge in pipelined mode. A read issued immediately after a write to the same word returns the newly written bytes.
- R4: `bw_n[i]` is active low and gates bits [9i+8:9i] of the word. A write with every `bw_n` bit high leaves the memory unchanged.
- R5: An edge with `cke_n` high is ignored. No command is taken, no pipeline stage moves, and a read data phase in progress keeps driving the same data.
- R6: During the data phase of a write, `dq_oe` is low even when `oe_n` is low.
- R7: While `oe_n` is high, `dq_oe` is low, independent of the clock.
- R8: A continue edge (`adv_ld` high) repeats the previous operation type. It ignores the chip enables and `we_n`, and for writes it uses the current `bw_n`. Address bits above the two low bits are held. The low bits are base+n mod 4 in linear order (`burst_il`=0) or base XOR n in interleaved order (`burst_il`=1), where n counts continues since the load, modulo 4.
- R9: A continue edge that follows a deselect is itself a deselect.
- R10: After reset, `dq_oe` is low, every pipeline stage holds a no-op, and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high stalls the edge |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Low selects write, high selects read on a load edge |
| adv_ld | input | 1 | Low loads a new address, high continues the burst |
| bw_n | input | NBYTES | Active-low byte write masks |
| addr | input | ADDR_W | Word address |
| pipe_mode | input | 1 | 1 selects pipelined timing, 0 flow-through |
| burst_il | input | 1 | 1 selects interleaved burst order, 0 linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_i | input | NBYTES*BYTE_W | Write data from the bus |
| dq_o | output | NBYTES*BYTE_W | Read data to the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The bench aims at direction changes on the bus: a write followed at once by a read of the same word, in both latency modes. Without forwarding in the pipelined path, that read would return the old word. Stalls placed inside read and write data phases catch a design that lets the clock enable move a stage, samples write data at a stalled edge, or drops the bus during a stalled read. Partial byte masks, all-masked writes, bursts that wrap in both orders, and continues after a deselect catch errors in lane gating, address order, or a burst that restarts from an idle state.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Operation held by each command stage
    typedef enum logic [1:0] {
        ZT_IDLE  = 2'd0,
        ZT_READ  = 2'd1,
        ZT_WRITE = 2'd2
    } zt_op_e;

endpackage

// File: rtl/zt_burst_ctr.sv
module zt_burst_ctr #(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               il,
    input  logic [BURST_W-1:0] base_in,
    output logic [BURST_W-1:0] nxt_low
);

    typedef struct packed {
        logic [BURST_W-1:0] base;
        logic [BURST_W-1:0] cnt;
    } bst_t;

    bst_t st_d, st_q;
    logic [BURST_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + 1'b1;
        if (load) begin
            st_d.base = base_in;
            st_d.cnt  = '0;
        end else if (step) begin
            st_d.cnt = cnt_inc;
        end
        // address of the next continue, counted from the loaded base
        nxt_low = il ? (st_q.base ^ cnt_inc) : (st_q.base + cnt_inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/zt_ctrl.sv
module zt_ctrl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int NBYTES  = 2,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic              adv_ld,
    input  logic [NBYTES-1:0] bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_il,
    output zt_op_e            s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [NBYTES-1:0] s1_be,
    output zt_op_e            s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [NBYTES-1:0] s2_be
);

    typedef struct packed {
        zt_op_e              op;
        logic [ADDR_W-1:0]   addr;
        logic [NBYTES-1:0]   be;
    } stage_t;

    stage_t s1_d, s1_q, s2_d, s2_q;
    logic   en, sel, ld, stp;
    logic [BURST_W-1:0] nxt_low;

    assign en  = !cke_n;
    assign sel = !ce1_n && ce2 && !ce3_n;
    assign ld  = en && !adv_ld && sel;
    assign stp = en && adv_ld && (s1_q.op != ZT_IDLE);

    zt_burst_ctr #(.BURST_W(BURST_W)) i_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld),
        .step    (stp),
        .il      (burst_il),
        .base_in (addr[BURST_W-1:0]),
        .nxt_low (nxt_low)
    );

    always_comb begin
        s1_d = s1_q;
        s2_d = s2_q;
        if (en) begin
            s2_d = s1_q;
            if (adv_ld) begin
                if (s1_q.op == ZT_IDLE) begin
                    s1_d.op   = ZT_IDLE;
                    s1_d.addr = '0;
                    s1_d.be   = '0;
                end else begin
                    s1_d.op   = s1_q.op;
                    s1_d.addr = {s1_q.addr[ADDR_W-1:BURST_W], nxt_low};
                    s1_d.be   = (s1_q.op == ZT_WRITE) ? ~bw_n : '0;
                end
            end else if (!sel) begin
                s1_d.op   = ZT_IDLE;
                s1_d.addr = '0;
                s1_d.be   = '0;
            end else begin
                s1_d.op   = we_n ? ZT_READ : ZT_WRITE;
                s1_d.addr = addr;
                s1_d.be   = we_n ? '0 : ~bw_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q.op   <= ZT_IDLE;
            s1_q.addr <= '0;
            s1_q.be   <= '0;
            s2_q.op   <= ZT_IDLE;
            s2_q.addr <= '0;
            s2_q.be   <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign s1_op   = s1_q.op;
    assign s1_addr = s1_q.addr;
    assign s1_be   = s1_q.be;
    assign s2_op   = s2_q.op;
    assign s2_addr = s2_q.addr;
    assign s2_be   = s2_q.be;

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !sel) |=> (s1_q.op == ZT_IDLE)); // R1

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> (s1_q == $past(s1_q)) && (s2_q == $past(s2_q))); // R5

    AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_n |=> (s2_q == $past(s1_q))); // R3

    AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && s1_q.op != ZT_IDLE) |=>
        (s1_q.addr[ADDR_W-1:BURST_W] == $past(s1_q.addr[ADDR_W-1:BURST_W]))
        && (s1_q.op == $past(s1_q.op))); // R8

    AST_DESEL_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && s1_q.op == ZT_IDLE) |=> (s1_q.op == ZT_IDLE)); // R9

endmodule

// File: rtl/zt_array.sv
module zt_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_be,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int DW    = NBYTES * BYTE_W;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_be[b]) begin
                    mem_d[wr_addr][b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane_chk
        AST_LANE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_be[g]) |=>
            (mem_q[$past(wr_addr)][g*BYTE_W +: BYTE_W]
             == $past(mem_q[wr_addr][g*BYTE_W +: BYTE_W]))); // R4
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int NBYTES  = 2,
    parameter int BYTE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke_n,
    input  logic                     ce1_n,
    input  logic                     ce2,
    input  logic                     ce3_n,
    input  logic                     we_n,
    input  logic                     adv_ld,
    input  logic [NBYTES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     pipe_mode,
    input  logic                     burst_il,
    input  logic                     oe_n,
    input  logic [NBYTES*BYTE_W-1:0] dq_i,
    output logic [NBYTES*BYTE_W-1:0] dq_o,
    output logic                     dq_oe
);

    localparam int DW = NBYTES * BYTE_W;

    typedef struct packed {
        logic [DW-1:0] data;
    } oreg_t;

    zt_op_e            s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [NBYTES-1:0] s1_be, s2_be;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [NBYTES-1:0] wr_be;
    logic [DW-1:0]     rd_data, fwd_data;
    zt_op_e            dph_op;
    oreg_t             out_d, out_q;

    zt_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BURST_W(BURST_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke_n    (cke_n),
        .ce1_n    (ce1_n),
        .ce2      (ce2),
        .ce3_n    (ce3_n),
        .we_n     (we_n),
        .adv_ld   (adv_ld),
        .bw_n     (bw_n),
        .addr     (addr),
        .burst_il (burst_il),
        .s1_op    (s1_op),
        .s1_addr  (s1_addr),
        .s1_be    (s1_be),
        .s2_op    (s2_op),
        .s2_addr  (s2_addr),
        .s2_be    (s2_be)
    );

    // the stage whose data phase is on the bus now
    always_comb begin
        dph_op  = pipe_mode ? s2_op   : s1_op;
        wr_addr = pipe_mode ? s2_addr : s1_addr;
        wr_be   = pipe_mode ? s2_be   : s1_be;
        wr_en   = !cke_n && (dph_op == ZT_WRITE);
    end

    zt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .wr_data (dq_i),
        .rd_addr (s1_addr),
        .rd_data (rd_data)
    );

    // bytes committed on this edge bypass the array into the output register
    for (genvar g = 0; g < NBYTES; g++) begin : g_fwd
        assign fwd_data[g*BYTE_W +: BYTE_W] =
            (wr_en && wr_be[g] && (wr_addr == s1_addr)) ?
            dq_i[g*BYTE_W +: BYTE_W] : rd_data[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        out_d = out_q;
        if (!cke_n) out_d.data = fwd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dq_o  = pipe_mode ? out_q.data : rd_data;
    assign dq_oe = !oe_n && (dph_op == ZT_READ);

    AST_OE_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R7

    AST_FT_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && !cke_n && !adv_ld && !we_n && !ce1_n && ce2 && !ce3_n)
        |=> !dq_oe); // R6

    AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && cke_n) |=> $stable(dq_o)); // R5

endmodule

// File: tb/test_zt_sram.sv
module test_zt_sram;

    localparam int AW = 4;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        int          kind;   // 0 idle, 1 read, 2 write
        logic [AW-1:0] a;
        logic [NB-1:0] be;
        logic [DW-1:0] d;
        int          src;    // 0 reset, 1 load, 2 idle continue, 3 burst continue
    } bc_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          ce1_n = 1'b1;
    logic          ce2 = 1'b1;
    logic          ce3_n = 1'b0;
    logic          we_n = 1'b1;
    logic          adv_ld = 1'b0;
    logic [NB-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic          pipe_mode = 1'b0;
    logic          burst_il = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int nchk = 0;
    int nfail = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    bc_t h0, h1;
    logic [1:0] bbase, bcnt;
    bit stalled;

    always #4 clk = ~clk;

    zt_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW), .BURST_W(2)) i_zt_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .we_n(we_n), .adv_ld(adv_ld), .bw_n(bw_n), .addr(addr),
        .pipe_mode(pipe_mode), .burst_il(burst_il), .oe_n(oe_n), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    function automatic bc_t idle_cmd(int src);
        bc_t c;
        c.kind = 0; c.a = '0; c.be = '0; c.d = '0; c.src = src;
        return c;
    endfunction

    function automatic logic [1:0] burst_low(logic [1:0] b, logic [1:0] n, bit il);
        return il ? (b ^ n) : (b + n);
    endfunction

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h (pipe=%0b)", tag, act, exp, pipe_mode);
        end
    endtask

    task automatic step(bit ck, bit e1n, bit e2v, bit e3n, bit wn, bit adv,
                        logic [NB-1:0] bwn, logic [AW-1:0] a, bit oen);
        bc_t act, nc;
        string tag;
        logic [DW-1:0] expd;
        @(negedge clk);
        oe_n = oen;
        #1;
        act = pipe_mode ? h1 : h0;
        if (act.kind == 1 && !oen) begin
            expd = ref_mem[act.a];
            tag = stalled ? "R5" : (act.src == 3 ? "R8" : "R2 R3 R4");
            chk(dq_oe == 1'b1, tag, {{(DW-1){1'b0}}, dq_oe}, 1);
            chk(dq_o == expd, tag, dq_o, expd);
        end else begin
            tag = oen ? "R7" : (act.kind == 2 ? "R6" :
                  (act.src == 0 ? "R10" : (act.src == 2 ? "R9" : "R1")));
            chk(dq_oe == 1'b0, tag, {{(DW-1){1'b0}}, dq_oe}, 0);
        end
        cke_n = ck; ce1_n = e1n; ce2 = e2v; ce3_n = e3n; we_n = wn;
        adv_ld = adv; bw_n = bwn; addr = a;
        dq_i = (act.kind == 2) ? act.d : DW'($urandom);
        nc = idle_cmd(1);
        if (!ck) begin
            if (adv) begin
                if (h0.kind == 0) begin
                    nc = idle_cmd(2);
                end else begin
                    bcnt = bcnt + 2'd1;
                    nc.kind = h0.kind;
                    nc.a = {h0.a[AW-1:2], burst_low(bbase, bcnt, burst_il)};
                    nc.be = (h0.kind == 2) ? ~bwn : '0;
                    nc.d = DW'($urandom);
                    nc.src = 3;
                end
            end else if (!(!e1n && e2v && !e3n)) begin
                nc = idle_cmd(1);
            end else begin
                nc.kind = wn ? 1 : 2;
                nc.a = a;
                nc.be = wn ? '0 : ~bwn;
                nc.d = DW'($urandom);
                nc.src = 1;
                bbase = a[1:0];
                bcnt = 2'd0;
            end
        end
        @(posedge clk);
        if (!ck) begin
            if (act.kind == 2) begin
                for (int b = 0; b < NB; b++)
                    if (act.be[b]) ref_mem[act.a][b*BW +: BW] = act.d[b*BW +: BW];
            end
            h1 = h0;
            h0 = nc;
        end
        stalled = ck;
    endtask

    task automatic idle_step();
        step(0, 1, 1, 0, 1, 0, '1, '0, 0);
    endtask

    task automatic do_reset(bit pm, bit il);
        @(negedge clk);
        rst_n = 1'b0;
        pipe_mode = pm;
        burst_il = il;
        cke_n = 1'b0; ce1_n = 1'b1; adv_ld = 1'b0; oe_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        h0 = idle_cmd(0);
        h1 = idle_cmd(0);
        bbase = 2'd0; bcnt = 2'd0; stalled = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic directed();
        // R10: bus idle and memory zero right after reset
        idle_step();
        step(0, 0, 1, 0, 1, 0, '1, 4'd5, 0);
        idle_step(); idle_step();
        // R3: write then immediate read of the same word, then write after read
        step(0, 0, 1, 0, 0, 0, 2'b00, 4'd3, 0);
        step(0, 0, 1, 0, 1, 0, 2'b11, 4'd3, 0);
        step(0, 0, 1, 0, 0, 0, 2'b10, 4'd3, 0);   // R4: only byte 0
        step(0, 0, 1, 0, 1, 0, 2'b11, 4'd3, 0);
        step(0, 0, 1, 0, 0, 0, 2'b11, 4'd3, 0);   // R4: write abort
        step(0, 0, 1, 0, 1, 0, 2'b11, 4'd3, 0);
        // R5: stalls inside data phases
        step(1, 0, 1, 0, 0, 0, 2'b00, 4'd7, 0);
        step(1, 0, 1, 0, 0, 0, 2'b00, 4'd7, 0);
        step(0, 0, 1, 0, 0, 0, 2'b01, 4'd7, 0);
        step(1, 1, 1, 0, 1, 0, 2'b11, 4'd0, 0);
        step(0, 0, 1, 0, 1, 0, 2'b11, 4'd7, 0);
        step(1, 1, 1, 0, 1, 0, 2'b11, 4'd0, 0);
        step(1, 1, 1, 0, 1, 0, 2'b11, 4'd0, 0);
        // R7: output enable forced off during a read
        step(0, 0, 1, 0, 1, 0, 2'b11, 4'd3, 1);
        step(0, 1, 1, 0, 1, 0, 2'b11, 4'd0, 1);
        step(0, 1, 1, 0, 1, 0, 2'b11, 4'd0, 0);
        // R8: burst write of four words from 9, then burst read wrapping
        step(0, 0, 1, 0, 0, 0, 2'b00, 4'd9, 0);
        step(0, 1, 0, 1, 1, 1, 2'b00, 4'd0, 0);
        step(0, 1, 0, 1, 1, 1, 2'b00, 4'd0, 0);
        step(0, 1, 0, 1, 1, 1, 2'b00, 4'd0, 0);
        step(0, 0, 1, 0, 1, 0, 2'b11, 4'd9, 0);
        step(0, 1, 0, 1, 0, 1, 2'b00, 4'd0, 0);
        step(0, 1, 0, 1, 0, 1, 2'b00, 4'd0, 0);
        step(0, 1, 0, 1, 0, 1, 2'b00, 4'd0, 0);
        step(0, 1, 0, 1, 0, 1, 2'b00, 4'd0, 0);   // fifth access wraps
        // R1, R9: deselect then continue
        step(0, 0, 0, 0, 1, 0, 2'b11, 4'd2, 0);
        step(0, 0, 1, 0, 1, 1, 2'b11, 4'd2, 0);
        step(0, 0, 1, 0, 0, 1, 2'b00, 4'd2, 0);
        idle_step(); idle_step(); idle_step();
    endtask

    task automatic random_run(int n);
        for (int i = 0; i < n; i++) begin
            bit ck, e1n, e2v, e3n, wn, adv, oen;
            logic [NB-1:0] bwn;
            logic [AW-1:0] a;
            ck  = ($urandom % 100) < 15;
            adv = ($urandom % 100) < 30;
            e1n = ($urandom % 100) < 5;
            e2v = ($urandom % 100) >= 4;
            e3n = ($urandom % 100) < 4;
            wn  = $urandom % 2;
            bwn = NB'($urandom);
            a   = AW'($urandom);
            oen = ($urandom % 100) < 8;
            step(ck, e1n, e2v, e3n, wn, adv, bwn, a, oen);
        end
        idle_step(); idle_step(); idle_step();
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset(1'b0, 1'b0); directed(); random_run(1500);
        do_reset(1'b1, 1'b1); directed(); random_run(1500);
        do_reset(1'b0, 1'b1); directed(); random_run(1500);
        do_reset(1'b1, 1'b0); directed(); random_run(1500);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule